// File: doc/BRIEF.md
# Two-Road Crossing Light Controller

This block drives the signal lamps at a crossing of two roads, called A and B. Each road has one vehicle sensor input and one two-bit lamp code output. The controller is a four-phase Moore machine. Road A keeps a green lamp for as long as its sensor reports traffic. When the sensor clears, road A shows yellow for exactly one clock. Road B then takes green for as long as its own sensor reports traffic, shows yellow for one clock, and control goes back to road A.

Both lamp codes are decoded only from the two registered state bits. The outputs therefore move only at a rising clock edge, and the sensors never reach the lamps through combinational logic. The reset is synchronous and active low, and it places the machine in the road-A-green phase.

The phase register uses a fixed binary encoding: A-green = 00, A-yellow = 01, B-green = 10, B-yellow = 11. Each lamp code is green = 00, yellow = 01, red = 10.

Top module: `xing_light_ctrl`

## Requirements
- R1: If rst_n is low at a rising clock edge, the lamps after that edge are A = 00 (green) and B = 10 (red), whatever the sensors show.
- R2: In the A-green phase with road_a_busy = 1, the next edge keeps A = 00 and B = 10.
- R3: In the A-green phase with road_a_busy = 0, the next edge gives A = 01 (yellow) and B = 10.
- R4: The A-yellow phase lasts exactly one clock and then moves to A = 10, B = 00, whatever both sensors show.
- R5: In the B-green phase with road_b_busy = 1, the next edge keeps A = 10 and B = 00.
- R6: In the B-green phase with road_b_busy = 0, the next edge gives A = 10 and B = 01 (yellow).
- R7: The B-yellow phase lasts exactly one clock and then moves to A = 00, B = 10, whatever both sensors show.
- R8: In every cycle at least one road shows red (10), and the code 11 never appears on either road.
- R9: A change on either sensor input does not change either lamp output until the next rising clock edge.
- R10: The sensor of the road that is currently red has no effect on the next phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| road_a_busy | input | 1 | Traffic present on road A |
| road_b_busy | input | 1 | Traffic present on road B |
| road_a_light | output | 2 | Lamp code for road A (00 green, 01 yellow, 10 red) |
| road_b_light | output | 2 | Lamp code for road B (00 green, 01 yellow, 10 red) |

## Verification
Two functions can act on the same edge: reset, and a phase change caused by a sensor. The clearest case is rst_n held low while the machine is in a green phase with that road's sensor at 0, so the sensor alone would start a yellow. The bench provokes this case directly and also through random reset pulses placed on top of random sensor traffic. It judges the result by requiring the road-A-green lamp pair right after the edge, with no yellow in between. A second overlap, a sensor edge in the same cycle as a forced yellow-to-green step, is judged by checking that the forced step is taken unchanged.

// File: rtl/xing_pkg.sv
// Shared types for the crossing light controller.
// Assumes a two-bit binary phase encoding that the lamp decoder reads bit by bit.
package xing_pkg;

    localparam int LAMP_W = 2;

    typedef enum logic [1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_t;

    typedef logic [LAMP_W-1:0] lamp_t;

    localparam lamp_t LAMP_GO   = 2'b00;
    localparam lamp_t LAMP_WARN = 2'b01;
    localparam lamp_t LAMP_STOP = 2'b10;

endpackage

// File: rtl/xing_phase_step.sv
// Phase register and next-phase logic for the crossing controller.
// Assumes: synchronous active-low reset; the sensors are already synchronous to clk.
// The next phase is formed from the two state bits and the sensors as sum-of-products.
module xing_phase_step
    import xing_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   busy_a,
    input  logic   busy_b,
    output phase_t phase_q
);

    logic hi_d;
    logic lo_d;

    // Next-phase equations: the high bit toggles after each yellow; the low bit marks a yellow.
    always_comb begin
        hi_d = phase_q[1] ^ phase_q[0];
        lo_d = (~phase_q[1] & ~phase_q[0] & ~busy_a) |
               ( phase_q[1] & ~phase_q[0] & ~busy_b);
    end

    // Phase register with synchronous reset into the road-A-green phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_A_GO;
        else        phase_q <= phase_t'({hi_d, lo_d});
    end

    // R1
    reset_to_a_chk: assert property (@(posedge clk) !rst_n |=> phase_q == PH_A_GO);

    // R2
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_A_GO && busy_a) |=> phase_q == PH_A_GO);

    // R3
    a_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_A_GO && !busy_a) |=> phase_q == PH_A_WARN);

    // R4
    a_warn_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_A_WARN |=> phase_q == PH_B_GO);

    // R5
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_B_GO && busy_b) |=> phase_q == PH_B_GO);

    // R6
    b_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_B_GO && !busy_b) |=> phase_q == PH_B_WARN);

    // R7
    b_warn_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_B_WARN |=> phase_q == PH_A_GO);

endmodule

// File: rtl/xing_lamp_decode.sv
// Lamp decoder: turns the registered phase into the two road lamp codes.
// Assumes the phase_t encoding from xing_pkg. The decoder reads the state bits only,
// so the lamps are a pure Moore function of the phase.
module xing_lamp_decode
    import xing_pkg::*;
(
    input  phase_t phase,
    output lamp_t  lamp_a,
    output lamp_t  lamp_b
);

    // Per-bit decode: a road is red while the other road owns the high phase bit.
    always_comb begin
        lamp_a = {  phase[1], ~phase[1] & phase[0] };
        lamp_b = { ~phase[1],  phase[1] & phase[0] };
    end

endmodule

// File: rtl/xing_light_ctrl.sv
// Top level of the two-road crossing light controller.
// Assumes: synchronous active-low reset and sensor inputs synchronous to clk.
// The lamps come only from the registered phase.
module xing_light_ctrl
    import xing_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       road_a_busy,
    input  logic       road_b_busy,
    output logic [1:0] road_a_light,
    output logic [1:0] road_b_light
);

    phase_t phase;
    lamp_t  lamp_a;
    lamp_t  lamp_b;

    xing_phase_step u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_a  (road_a_busy),
        .busy_b  (road_b_busy),
        .phase_q (phase)
    );

    xing_lamp_decode u_lamp (
        .phase  (phase),
        .lamp_a (lamp_a),
        .lamp_b (lamp_b)
    );

    // Drive the output pins from the decoder.
    always_comb begin
        road_a_light = lamp_a;
        road_b_light = lamp_b;
    end

    // R8
    one_road_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (road_a_light == LAMP_STOP) || (road_b_light == LAMP_STOP));

    // R8
    no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (road_a_light != 2'b11) && (road_b_light != 2'b11));

    // R8
    b_green_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_B_GO |-> (road_a_light == LAMP_STOP && road_b_light == LAMP_GO));

    // R8
    a_warn_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_A_WARN |-> (road_a_light == LAMP_WARN && road_b_light == LAMP_STOP));

endmodule

// File: tb/sim_xing_light_ctrl.sv
module sim_xing_light_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       road_a_busy = 1'b0;
    logic       road_b_busy = 1'b0;
    logic [1:0] road_a_light;
    logic [1:0] road_b_light;

    int checks = 0;
    int failures = 0;
    int mphase = 0;   // model phase: 0 A-green, 1 A-yellow, 2 B-green, 3 B-yellow

    xing_light_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .road_a_busy  (road_a_busy),
        .road_b_busy  (road_b_busy),
        .road_a_light (road_a_light),
        .road_b_light (road_b_light)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic int next_phase(int ph, logic a, logic b, logic rn);
        if (!rn) return 0;
        case (ph)
            0:       return a ? 0 : 1;
            1:       return 2;
            2:       return b ? 2 : 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] exp_a(int ph);
        return (ph == 0) ? 2'b00 : (ph == 1) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] exp_b(int ph);
        return (ph == 2) ? 2'b00 : (ph == 3) ? 2'b01 : 2'b10;
    endfunction

    function automatic string req_of(int ph, logic a, logic b, logic rn);
        if (!rn) return "R1";
        case (ph)
            0:       return a ? "R2" : "R3";
            1:       return "R4";
            2:       return b ? "R5" : "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check2(string req, logic [1:0] act_a, logic [1:0] act_b,
                          logic [1:0] e_a, logic [1:0] e_b);
        checks++;
        if (act_a !== e_a || act_b !== e_b) begin
            failures++;
            $display("FAIL %s: lamps A=%b B=%b, expected A=%b B=%b", req, act_a, act_b, e_a, e_b);
        end
    endtask

    // One clock: drive inputs at the falling edge, check that the lamps do not move (R9),
    // advance the model at the rising edge, then check the new lamps.
    task automatic step(logic rn, logic a, logic b, string tag);
        logic [1:0] pa;
        logic [1:0] pb;
        string      req;
        @(negedge clk);
        pa = road_a_light;
        pb = road_b_light;
        rst_n = rn;
        road_a_busy = a;
        road_b_busy = b;
        #2;
        check2("R9", road_a_light, road_b_light, pa, pb);
        req = (tag != "") ? tag : req_of(mphase, a, b, rn);
        @(posedge clk);
        mphase = next_phase(mphase, a, b, rn);
        #5;
        check2(req, road_a_light, road_b_light, exp_a(mphase), exp_b(mphase));
        checks++;
        if (road_a_light != 2'b10 && road_b_light != 2'b10) begin
            failures++;
            $display("FAIL R8: no road red, A=%b B=%b, expected one 10", road_a_light, road_b_light);
        end
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog: run not finished, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        step(1'b0, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b0, "R1");
        // R2 and R10: A held while busy, B sensor ignored
        step(1'b1, 1'b1, 1'b1, "R10");
        step(1'b1, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b1, "R2");
        // R3: A releases
        step(1'b1, 1'b0, 1'b1, "R3");
        // R4: yellow is forced on, with sensors asking otherwise
        step(1'b1, 1'b1, 1'b0, "R4");
        // R5 and R10: B held, A sensor ignored
        step(1'b1, 1'b1, 1'b1, "R10");
        step(1'b1, 1'b0, 1'b1, "R5");
        // R6: B releases
        step(1'b1, 1'b1, 1'b0, "R6");
        // R7: yellow is forced on to A green
        step(1'b1, 1'b0, 1'b1, "R7");
        // R1 with R3 on the same edge: reset beats the release
        step(1'b1, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b0, 1'b0, "R1");
        // Reset while B is green and releasing
        step(1'b1, 1'b0, 1'b0, "R3");
        step(1'b1, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, "R1");
        // Random traffic with occasional reset
        for (int i = 0; i < 600; i++) begin
            logic rn;
            logic a;
            logic b;
            rn = ($urandom % 40) != 0;
            a  = ($urandom % 3) != 0;
            b  = ($urandom % 3) != 0;
            step(rn, a, b, "");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule